// File: doc/BRIEF.md
# Multi-Level Indirect Address Resolver

This block turns a memory-indirect operand reference into a final effective address. Given a starting address, it reads the word stored there through a single-outstanding synchronous memory port. Each fetched word carries an address field, an index-register selector and an indirection tag. The selected index register value (if any) is added to the address field. When the tag is set, the result is the location of yet another pointer and the block reads again; when the tag is clear, the result is the effective address and is reported with a one-cycle done strobe. Chains have no length limit.

Sixteen low memory cells act as auto-index cells. When a read lands on one of them, the cell's address field is stepped by one (up for the lower eight cells, down for the upper eight), the modified word is written back, and the modified address is used for the rest of that level. The walk can be interrupted: a pending interrupt seen when a fetched word returns aborts the resolution before anything from that level is written, so the instruction can be restarted from scratch.

The index register file belongs to the surrounding core. The block presents a selector and expects the selected value back in the same cycle.

Top module: `ptr_chain_resolver`

## Requirements
- R1: After reset the block is idle: busy, done, abort and mem_req are all low.
- R2: A start pulse while idle issues a read (mem_req high, mem_we low) of start_addr in the cycle that follows.
- R3: Word layout: bit 35 is the indirection tag, bits 21..18 select an index register, bits 17..0 hold the address field. A fetched word with bit 35 clear ends the walk and the computed address appears on eff_addr with done.
- R4: While the fetched word has bit 35 set, the computed address is read next, for any number of levels, including a chain that points to itself.
- R5: A nonzero selector adds idx_val (the value of register idx_sel) to the address field, modulo 2^18; a zero selector adds nothing.
- R6: A read of location 16..23 increments the word's address field by one (modulo 2^18), keeps the other bits, writes the whole word back to the same location, and continues with the modified word. Locations 15 and 32 are not modified.
- R7: A read of location 24..31 does the same with a decrement by one.
- R8: An interrupt pending when a read response arrives aborts the walk with a one-cycle abort pulse; no write-back of that level takes place and the block returns to idle.
- R9: At most one memory request is outstanding; no new request is raised before the response to the previous one.
- R10: A start pulse while busy is ignored and does not change the result.
- R11: done and abort are one-cycle pulses and never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a resolution (taken only when idle) |
| start_addr | input | 18 | Address of the first pointer word |
| irq | input | 1 | Interrupt pending |
| busy | output | 1 | A resolution is in progress |
| mem_req | output | 1 | One-cycle memory request |
| mem_we | output | 1 | Request is a write (auto-index write-back) |
| mem_addr | output | 18 | Request address |
| mem_wdata | output | 36 | Write data |
| mem_rvalid | input | 1 | Response strobe for the outstanding request |
| mem_rdata | input | 36 | Read data, valid with mem_rvalid |
| idx_sel | output | 4 | Index register selector, zero when no lookup is needed |
| idx_val | input | 18 | Value of the selected index register |
| done | output | 1 | One-cycle strobe, eff_addr valid |
| abort | output | 1 | One-cycle strobe, resolution abandoned for an interrupt |
| eff_addr | output | 18 | Final effective address |

## Verification
A corrupted step inside the walk shows up at the ports within one level: a wrong address field or index sum sends the next read to the wrong location on mem_addr, and a wrong auto-index decision produces an unexpected write or a memory image that differs from the expected one when done arrives. A faulty interrupt path shows as a write-back or a done where an abort was due, visible within a cycle or two of the read response. Random memories built from terminating chains are compared against a reference walk for both the effective address and the full memory contents afterwards, alongside directed cases for wraparound, cell range edges, self-loops and restart-safe aborts.

// File: rtl/pcr_pkg.sv
package pcr_pkg;

    typedef enum logic [2:0] {
        S_IDLE    = 3'd0,
        S_RD      = 3'd1,
        S_RD_WAIT = 3'd2,
        S_WR      = 3'd3,
        S_WR_WAIT = 3'd4,
        S_CALC    = 3'd5
    } pcr_state_e;

endpackage

// File: rtl/pcr_auto_cell.sv
// Detects an auto-index location and produces the stepped word.
module pcr_auto_cell #(
    parameter int ADDR_W   = 18,
    parameter int WORD_W   = 36,
    parameter int INC_BASE = 16,
    parameter int DEC_BASE = 24,
    parameter int AUTO_CNT = 8
) (
    input  logic [ADDR_W-1:0] cell_addr,
    input  logic [WORD_W-1:0] word_in,
    output logic              is_auto,
    output logic [WORD_W-1:0] word_out
);
    localparam logic [ADDR_W-1:0] INC_LO = ADDR_W'(INC_BASE);
    localparam logic [ADDR_W-1:0] INC_HI = ADDR_W'(INC_BASE + AUTO_CNT);
    localparam logic [ADDR_W-1:0] DEC_LO = ADDR_W'(DEC_BASE);
    localparam logic [ADDR_W-1:0] DEC_HI = ADDR_W'(DEC_BASE + AUTO_CNT);
    localparam logic [ADDR_W-1:0] ONE    = ADDR_W'(1);

    logic in_inc;
    logic in_dec;

    always_comb begin
        in_inc   = (cell_addr >= INC_LO) && (cell_addr < INC_HI);
        in_dec   = (cell_addr >= DEC_LO) && (cell_addr < DEC_HI);
        is_auto  = in_inc || in_dec;
        word_out = word_in;
        if (in_inc) begin
            word_out[ADDR_W-1:0] = word_in[ADDR_W-1:0] + ONE;
        end else if (in_dec) begin
            word_out[ADDR_W-1:0] = word_in[ADDR_W-1:0] - ONE;
        end
    end

endmodule

// File: rtl/pcr_next_addr.sv
// Adds the optional index value to a pointer word's address field.
module pcr_next_addr #(
    parameter int ADDR_W = 18,
    parameter int SEL_W  = 4
) (
    input  logic [ADDR_W-1:0] field_addr,
    input  logic [SEL_W-1:0]  field_sel,
    input  logic [ADDR_W-1:0] idx_val,
    output logic [ADDR_W-1:0] next_addr
);
    logic [ADDR_W-1:0] addend;

    always_comb begin
        addend    = (field_sel != '0) ? idx_val : '0;
        next_addr = field_addr + addend;
    end

endmodule

// File: rtl/ptr_chain_resolver.sv
module ptr_chain_resolver
    import pcr_pkg::*;
#(
    parameter int ADDR_W   = 18,
    parameter int WORD_W   = 36,
    parameter int IND_BIT  = 35,
    parameter int SEL_LSB  = 18,
    parameter int SEL_W    = 4,
    parameter int INC_BASE = 16,
    parameter int DEC_BASE = 24,
    parameter int AUTO_CNT = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              irq,
    output logic              busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_rvalid,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [SEL_W-1:0]  idx_sel,
    input  logic [ADDR_W-1:0] idx_val,
    output logic              done,
    output logic              abort,
    output logic [ADDR_W-1:0] eff_addr
);

    typedef struct packed {
        pcr_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] word;
        logic [ADDR_W-1:0] ea;
        logic              done;
        logic              abort;
    } regs_t;

    regs_t r_q, r_d;

    logic              cell_auto;
    logic [WORD_W-1:0] cell_word;
    logic [ADDR_W-1:0] calc_addr;

    pcr_auto_cell #(
        .ADDR_W  (ADDR_W),
        .WORD_W  (WORD_W),
        .INC_BASE(INC_BASE),
        .DEC_BASE(DEC_BASE),
        .AUTO_CNT(AUTO_CNT)
    ) i_auto (
        .cell_addr(r_q.addr),
        .word_in  (mem_rdata),
        .is_auto  (cell_auto),
        .word_out (cell_word)
    );

    pcr_next_addr #(
        .ADDR_W(ADDR_W),
        .SEL_W (SEL_W)
    ) i_next (
        .field_addr(r_q.word[ADDR_W-1:0]),
        .field_sel (r_q.word[SEL_LSB +: SEL_W]),
        .idx_val   (idx_val),
        .next_addr (calc_addr)
    );

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        r_d.abort = 1'b0;
        unique case (r_q.st)
            S_IDLE: begin
                if (start) begin
                    r_d.addr = start_addr;
                    r_d.st   = S_RD;
                end
            end
            S_RD: r_d.st = S_RD_WAIT;
            S_RD_WAIT: begin
                if (mem_rvalid) begin
                    if (irq) begin
                        r_d.abort = 1'b1;
                        r_d.st    = S_IDLE;
                    end else begin
                        r_d.word = cell_word;
                        r_d.st   = cell_auto ? S_WR : S_CALC;
                    end
                end
            end
            S_WR: r_d.st = S_WR_WAIT;
            S_WR_WAIT: begin
                if (mem_rvalid) begin
                    r_d.st = S_CALC;
                end
            end
            S_CALC: begin
                if (r_q.word[IND_BIT]) begin
                    r_d.addr = calc_addr;
                    r_d.st   = S_RD;
                end else begin
                    r_d.ea   = calc_addr;
                    r_d.done = 1'b1;
                    r_d.st   = S_IDLE;
                end
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy      = (r_q.st != S_IDLE);
    assign mem_req   = (r_q.st == S_RD) || (r_q.st == S_WR);
    assign mem_we    = (r_q.st == S_WR);
    assign mem_addr  = r_q.addr;
    assign mem_wdata = r_q.word;
    assign idx_sel   = (r_q.st == S_CALC) ? r_q.word[SEL_LSB +: SEL_W] : '0;
    assign done      = r_q.done;
    assign abort     = r_q.abort;
    assign eff_addr  = r_q.ea;

endmodule

// File: rtl/pcr_checker.sv
module pcr_checker #(
    parameter int ADDR_W   = 18,
    parameter int INC_BASE = 16,
    parameter int DEC_BASE = 24,
    parameter int AUTO_CNT = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [ADDR_W-1:0] start_addr,
    input logic              irq,
    input logic              busy,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_rvalid,
    input logic              done,
    input logic              abort
);
    logic pending_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending_q <= 1'b0;
        end else if (mem_req) begin
            pending_q <= 1'b1;
        end else if (mem_rvalid) begin
            pending_q <= 1'b0;
        end
    end

    // R9
    single_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pending_q |-> !mem_req);

    // R11
    excl_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && abort));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    abort_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort |-> $past(mem_rvalid && irq));

    // R2
    launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (mem_req && !mem_we && mem_addr == $past(start_addr)));

    // R6
    wr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |->
            ((mem_addr >= ADDR_W'(INC_BASE) && mem_addr < ADDR_W'(INC_BASE + AUTO_CNT)) ||
             (mem_addr >= ADDR_W'(DEC_BASE) && mem_addr < ADDR_W'(DEC_BASE + AUTO_CNT))));

endmodule

bind ptr_chain_resolver pcr_checker #(
    .ADDR_W  (ADDR_W),
    .INC_BASE(INC_BASE),
    .DEC_BASE(DEC_BASE),
    .AUTO_CNT(AUTO_CNT)
) i_pcr_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .start_addr(start_addr),
    .irq       (irq),
    .busy      (busy),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_rvalid(mem_rvalid),
    .done      (done),
    .abort     (abort)
);

// File: tb/test_ptr_chain_resolver.sv
module test_ptr_chain_resolver;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [17:0] start_addr;
    logic        irq;
    logic        busy;
    logic        mem_req;
    logic        mem_we;
    logic [17:0] mem_addr;
    logic [35:0] mem_wdata;
    logic        mem_rvalid;
    logic [35:0] mem_rdata;
    logic [3:0]  idx_sel;
    logic [17:0] idx_val;
    logic        done;
    logic        abort;
    logic [17:0] eff_addr;

    logic [35:0] mem    [256];
    logic [35:0] shadow [256];
    logic [17:0] idx_reg[16];

    int nvec = 0;
    int nfail = 0;
    int wr_cnt = 0;
    int proto_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign idx_val = idx_reg[idx_sel];

    ptr_chain_resolver i_ptr_chain_resolver (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .irq(irq), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .idx_sel(idx_sel), .idx_val(idx_val),
        .done(done), .abort(abort), .eff_addr(eff_addr)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Memory model: responds 1..3 cycles after a request, all activity at negedge.
    initial begin
        mem_rvalid = 1'b0;
        mem_rdata  = '0;
        forever begin
            @(negedge clk);
            mem_rvalid = 1'b0;
            if (mem_req) begin
                logic [7:0]  a;
                logic        w;
                int          lat;
                a = mem_addr[7:0];
                w = mem_we;
                if (w) begin
                    mem[a] = mem_wdata;
                    wr_cnt++;
                end
                lat = int'($urandom_range(0, 2));
                for (int k = 0; k <= lat; k++) begin
                    @(negedge clk);
                    if (mem_req) proto_err++;
                end
                mem_rvalid = 1'b1;
                mem_rdata  = w ? '0 : mem[a];
            end
        end
    end

    // Reference walk over the shadow image
    function automatic logic [17:0] ref_resolve(input logic [17:0] a0);
        logic [17:0] a;
        logic [35:0] w;
        logic [17:0] n;
        a = a0;
        for (int lv = 0; lv < 400; lv++) begin
            w = shadow[a[7:0]];
            if (a >= 18'd16 && a < 18'd24) begin
                w[17:0] = w[17:0] + 18'd1;
                shadow[a[7:0]] = w;
            end else if (a >= 18'd24 && a < 18'd32) begin
                w[17:0] = w[17:0] - 18'd1;
                shadow[a[7:0]] = w;
            end
            n = w[17:0] + ((w[21:18] != 4'd0) ? idx_reg[w[21:18]] : 18'd0);
            if (!w[35]) return n;
            a = n;
        end
        return '1;
    endfunction

    function automatic logic [35:0] mk(input bit ind, input logic [3:0] sel,
                                       input logic [17:0] fld);
        return {ind, 13'h0a5a, sel, fld};
    endfunction

    task automatic run_one(input logic [17:0] a, input bit poke, input int irq_after,
                           output bit gd, output bit ga, output logic [17:0] ea,
                           output int plen, output bit launch_ok, output bit busy_seen);
        @(negedge clk);
        start = 1'b1;
        start_addr = a;
        @(negedge clk);
        start = 1'b0;
        start_addr = ~a;
        launch_ok = mem_req && !mem_we && (mem_addr == a);
        gd = 0; ga = 0; ea = '0; plen = 0; busy_seen = 0;
        for (int c = 0; c < 3000; c++) begin
            if (poke && c == 1) start = 1'b1;
            if (poke && c == 2) start = 1'b0;
            if (irq_after >= 0 && c == irq_after) begin
                busy_seen = busy;
                irq = 1'b1;
            end
            if (done) begin gd = 1; ea = eff_addr; break; end
            if (abort) begin ga = 1; break; end
            @(negedge clk);
        end
        if (gd || ga) begin
            @(negedge clk);
            plen = (done || abort) ? 2 : 1;
        end
        irq = 1'b0;
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) mem[i] = mk(1'b0, 4'd0, 18'(i));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        bit          gd, ga, lok, bsy;
        logic [17:0] ea, exp;
        int          plen, wr0, diff;
        void'($urandom(32'h5eed_1234));
        rst_n = 1'b0; start = 1'b0; start_addr = '0; irq = 1'b0;
        for (int i = 0; i < 16; i++) idx_reg[i] = '0;
        clear_mem();
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!busy && !done && !abort && !mem_req, "R1 reset idle",
            {busy, done, abort, mem_req}, 4'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !mem_req, "R1 idle after release", {busy, mem_req}, 2'b0);

        // R2, R3: single level, tag clear
        mem[100] = mk(1'b0, 4'd0, 18'd777);
        run_one(18'd100, 0, -1, gd, ga, ea, plen, lok, bsy);
        chk(lok, "R2 launch read of start_addr", lok, 1);
        chk(gd && ea == 18'd777, "R3 direct result", ea, 18'd777);
        chk(plen == 1 && !ga, "R11 done single cycle", plen, 1);

        // R5: index add with modular wrap, and zero selector
        idx_reg[3] = 18'h3ffff;
        mem[100] = mk(1'b0, 4'd3, 18'd5);
        run_one(18'd100, 0, -1, gd, ga, ea, plen, lok, bsy);
        chk(gd && ea == 18'd4, "R5 index wrap", ea, 18'd4);
        mem[101] = mk(1'b1, 4'd0, 18'd102);
        mem[102] = mk(1'b0, 4'd3, 18'd40);
        idx_reg[3] = 18'd9;
        run_one(18'd101, 0, -1, gd, ga, ea, plen, lok, bsy);
        chk(gd && ea == 18'd49, "R4 two-level chain with R5 index", ea, 18'd49);

        // R6: increment cell wraps, upper bits kept
        mem[17] = mk(1'b0, 4'd0, 18'h3ffff);
        wr0 = wr_cnt;
        run_one(18'd17, 0, -1, gd, ga, ea, plen, lok, bsy);
        chk(gd && ea == 18'd0, "R6 increment wrap result", ea, 18'd0);
        chk(mem[17] == mk(1'b0, 4'd0, 18'd0), "R6 increment write-back", mem[17],
            mk(1'b0, 4'd0, 18'd0));
        chk(wr_cnt == wr0 + 1, "R6 one write", wr_cnt - wr0, 1);

        // R7: decrement cell reached through a chain, and range edges
        mem[50] = mk(1'b1, 4'd0, 18'd24);
        mem[24] = mk(1'b0, 4'd0, 18'd0);
        run_one(18'd50, 0, -1, gd, ga, ea, plen, lok, bsy);
        chk(gd && ea == 18'h3ffff, "R7 decrement result", ea, 18'h3ffff);
        chk(mem[24] == mk(1'b0, 4'd0, 18'h3ffff), "R7 decrement write-back", mem[24],
            mk(1'b0, 4'd0, 18'h3ffff));
        mem[31] = mk(1'b0, 4'd0, 18'd300);
        run_one(18'd31, 0, -1, gd, ga, ea, plen, lok, bsy);
        chk(gd && ea == 18'd299, "R7 last decrement cell", ea, 18'd299);
        mem[23] = mk(1'b0, 4'd0, 18'd300);
        run_one(18'd23, 0, -1, gd, ga, ea, plen, lok, bsy);
        chk(gd && ea == 18'd301, "R6 last increment cell", ea, 18'd301);
        mem[15] = mk(1'b0, 4'd0, 18'd9);
        mem[32] = mk(1'b0, 4'd0, 18'd9);
        wr0 = wr_cnt;
        run_one(18'd15, 0, -1, gd, ga, ea, plen, lok, bsy);
        chk(gd && ea == 18'd9, "R6 cell 15 untouched result", ea, 18'd9);
        run_one(18'd32, 0, -1, gd, ga, ea, plen, lok, bsy);
        chk(gd && ea == 18'd9 && wr_cnt == wr0, "R6 cells 15 and 32 not written",
            wr_cnt - wr0, 0);

        // R8: interrupt pending at the first response of an auto cell
        mem[20] = mk(1'b1, 4'd0, 18'd20);
        wr0 = wr_cnt;
        irq = 1'b1;
        run_one(18'd20, 0, -1, gd, ga, ea, plen, lok, bsy);
        chk(ga && !gd, "R8 abort on pending interrupt", {ga, gd}, 2'b10);
        chk(wr_cnt == wr0 && mem[20] == mk(1'b1, 4'd0, 18'd20),
            "R8 no write-back on abort", mem[20], mk(1'b1, 4'd0, 18'd20));
        chk(plen == 1, "R11 abort single cycle", plen, 1);
        @(negedge clk);
        chk(!busy, "R8 idle after abort", busy, 0);

        // R4 + R8: endless self-pointer keeps walking until interrupted
        mem[5] = mk(1'b1, 4'd0, 18'd5);
        run_one(18'd5, 0, 200, gd, ga, ea, plen, lok, bsy);
        chk(bsy, "R4 self chain still busy", bsy, 1);
        chk(ga && !gd, "R8 self chain aborted", {ga, gd}, 2'b10);

        // R10: start while busy ignored
        mem[60] = mk(1'b1, 4'd0, 18'd61);
        mem[61] = mk(1'b0, 4'd0, 18'd1234);
        run_one(18'd60, 1, -1, gd, ga, ea, plen, lok, bsy);
        chk(gd && ea == 18'd1234, "R10 start while busy ignored", ea, 18'd1234);
        repeat (6) @(negedge clk);
        chk(!busy && !mem_req, "R10 no second walk launched", {busy, mem_req}, 2'b0);

        // Random memories with terminating chains
        for (int t = 0; t < 40; t++) begin
            logic [17:0] st;
            idx_reg[0] = '0;
            for (int i = 1; i < 16; i++) idx_reg[i] = 18'($urandom_range(0, 23));
            for (int a = 0; a < 256; a++) begin
                logic [3:0]  sel;
                logic [17:0] fld, eff, n;
                bit          ind;
                sel = ($urandom_range(0, 1) == 1) ? 4'($urandom_range(1, 15)) : 4'd0;
                fld = 18'($urandom_range(0, 255));
                eff = fld;
                if (a >= 16 && a < 24) eff = fld + 18'd1;
                else if (a >= 24 && a < 32) eff = fld - 18'd1;
                n = eff + ((sel != 0) ? idx_reg[sel] : 18'd0);
                ind = ($urandom_range(0, 1) == 1) && (n > 18'(a)) && (n < 18'd256);
                mem[a] = {ind, 13'($urandom), sel, fld};
            end
            for (int a = 0; a < 256; a++) shadow[a] = mem[a];
            st  = 18'($urandom_range(0, 255));
            exp = ref_resolve(st);
            run_one(st, 0, -1, gd, ga, ea, plen, lok, bsy);
            chk(gd && ea == exp, "R4 random chain result", ea, exp);
            diff = 0;
            for (int a = 0; a < 256; a++) if (mem[a] != shadow[a]) diff++;
            chk(diff == 0, "R6 R7 random memory image", diff, 0);
        end

        chk(proto_err == 0, "R9 single outstanding request", proto_err, 0);
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule